// File: doc/BRIEF.md
# Serial Audio Link Outbound Frame Builder

This block produces the outgoing half of a serial audio link of the AC'97 kind. It runs on the bit clock that the codec supplies. It drives two lines: a frame sync pulse and a single serial data line. Every frame is 256 bit periods long. It opens with a 16-bit tag field and continues with twelve 20-bit data slots. At the nominal 12.288 MHz bit clock this gives a 48 kHz frame rate. Both lines change on the rising clock edge, and the codec samples them on the falling edge that follows.

The parallel side offers one valid flag and one 16-bit sample for each of slots 1 to 12. The block captures all of these into a shadow copy once per frame, at the clock edge that launches the last bit of the frame before. The tag field is built from the captured flags. Each valid sample is sent most significant bit first in the upper 16 bits of its slot, followed by four zero bits. An invalid slot is sent as all zeros.

Top module: `aclink_frame_tx`

## Requirements
- R1: While `rst_n` is sampled low, `sync_o` and `sdout_o` are 0 after the edge. The first rising edge with `rst_n` high begins a new frame: `sync_o` goes to 1 after that edge and `sdout_o` stays 0.
- R2: `sync_o` is 1 for exactly 16 consecutive bit clocks and then 0 for 240, so it rises every 256 bit clocks.
- R3: `sdout_o` lags `sync_o` by one bit clock. Frame bit 0 appears on the edge after the one that raised `sync_o`, and frame bit 255 is on the line during the first cycle of the next sync pulse.
- R4: Frame bit 0 (tag bit 15) is 1 exactly when at least one captured slot valid flag is set.
- R5: Frame bits 1 to 12 (tag bits 14 to 3) carry the captured valid flags of slots 1 to 12 in that order. Frame bits 13 to 15 (tag bits 2 to 0) are 0.
- R6: For slot s (1 to 12), frame bits 16+20(s-1) to 16+20(s-1)+15 carry `slot_data_i[16(s-1)+15 : 16(s-1)]` most significant bit first, when slot s is captured valid.
- R7: The last 4 bits of every valid slot are 0.
- R8: All 20 bits of a slot whose captured valid flag is 0 are sent as 0, whatever its data input holds.
- R9: The inputs are captured only at the edge that raises `sync_o`. Changes to the inputs at any other time have no effect on the frame currently being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid_i | input | 12 | Valid flag per data slot; bit s-1 belongs to slot s |
| slot_data_i | input | 192 | 16-bit samples; slot s at bits 16(s-1)+15 down to 16(s-1) |
| sync_o | output | 1 | Frame sync, high during the 16-bit tag phase |
| sdout_o | output | 1 | Serial frame data, most significant bit first |

## Verification
The assertions watch only the two output lines. They rebuild the frame position from the rising edge of sync. They assume that once reset is released it stays high long enough for whole frames to pass, and that the parallel inputs never feed back into the frame timing. The bench meets both conditions. It releases reset once per run and holds it low only for a short burst in the middle of a frame, and the assertions are disabled during that burst. It changes the parallel inputs twice per frame, away from the capture edge: first to scrambled values, then to the pattern meant for the next frame. Every bit of every frame is compared against a model that captures at the same edge.

// File: rtl/aclink_tx_pkg.sv
// Package: shared defaults for the outbound frame builder.
// Assumes: tag field is wide enough to hold one bit per slot plus the
// frame-valid bit.
package aclink_tx_pkg;
    localparam int DEF_NUM_SLOTS = 12;
    localparam int DEF_SAMPLE_W  = 16;
    localparam int DEF_SLOT_W    = 20;
    localparam int DEF_TAG_W     = 16;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_TAG  = 1'b1
    } phase_e;
endpackage

// File: rtl/aclink_bit_timer.sv
// Module: walks the frame bit by bit.
// Tracks the phase (tag or data), the slot index and a down-counting bit
// index within the current field. Also presents a one-cycle-delayed copy
// of that position, which is the position of the bit being launched.
// Assumes: TAG_W and SLOT_W do not exceed 2**BIT_W.
module aclink_bit_timer
    import aclink_tx_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int SLOT_W    = DEF_SLOT_W,
    parameter int TAG_W     = DEF_TAG_W,
    parameter int BIT_W     = 5,
    parameter int SIDX_W    = 4
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    output phase_e            cur_phase,
    output logic              frame_start,
    output phase_e            lch_phase,
    output logic [SIDX_W-1:0] lch_slot,
    output logic [BIT_W-1:0]  lch_bit,
    output logic              lch_en
);
    localparam logic [BIT_W-1:0]  TAG_TOP  = BIT_W'(TAG_W - 1);
    localparam logic [BIT_W-1:0]  SLOT_TOP = BIT_W'(SLOT_W - 1);
    localparam logic [SIDX_W-1:0] LAST_SL  = SIDX_W'(NUM_SLOTS - 1);

    phase_e            phase_q, phase_d;
    logic [SIDX_W-1:0] slot_q, slot_d;
    logic [BIT_W-1:0]  bit_q, bit_d;

    // Next position: count the bit index down, then move to the next field.
    always_comb begin
        phase_d = phase_q;
        slot_d  = slot_q;
        bit_d   = bit_q - 1'b1;
        if (bit_q == '0) begin
            if (phase_q == PH_TAG) begin
                phase_d = PH_DATA;
                slot_d  = '0;
                bit_d   = SLOT_TOP;
            end else if (slot_q == LAST_SL) begin
                phase_d = PH_TAG;
                slot_d  = '0;
                bit_d   = TAG_TOP;
            end else begin
                slot_d = slot_q + 1'b1;
                bit_d  = SLOT_TOP;
            end
        end
    end

    // Position register; reset parks it on the first tag bit.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            phase_q <= PH_TAG;
            slot_q  <= '0;
            bit_q   <= TAG_TOP;
        end else begin
            phase_q <= phase_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
        end
    end

    // Launch copy: one cycle behind, enabled after the first active edge.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            lch_phase <= PH_TAG;
            lch_slot  <= '0;
            lch_bit   <= TAG_TOP;
            lch_en    <= 1'b0;
        end else begin
            lch_phase <= phase_q;
            lch_slot  <= slot_q;
            lch_bit   <= bit_q;
            lch_en    <= 1'b1;
        end
    end

    assign cur_phase   = phase_q;
    assign frame_start = (phase_q == PH_TAG) && (bit_q == TAG_TOP);
endmodule

// File: rtl/aclink_slot_shadow.sv
// Module: per-frame shadow of the parallel slot inputs.
// Captures flags and samples only on the frame-start edge, so the frame
// in flight never sees mid-frame input changes.
// Assumes: capture pulse is one cycle wide per frame.
module aclink_slot_shadow #(
    parameter int NUM_SLOTS = 12,
    parameter int SAMPLE_W  = 16
) (
    input  logic                          bit_clk,
    input  logic                          rst_n,
    input  logic                          capture,
    input  logic [NUM_SLOTS-1:0]          valid_in,
    input  logic [NUM_SLOTS*SAMPLE_W-1:0] data_in,
    output logic [NUM_SLOTS-1:0]          valid_sh,
    output logic [NUM_SLOTS*SAMPLE_W-1:0] data_sh
);
    // Shadow register, loaded once per frame.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            valid_sh <= '0;
            data_sh  <= '0;
        end else if (capture) begin
            valid_sh <= valid_in;
            data_sh  <= data_in;
        end
    end
endmodule

// File: rtl/aclink_bit_select.sv
// Module: picks the frame bit for a given launch position.
// Builds the tag word and one padded word per slot, then indexes them.
// Assumes: TAG_W >= NUM_SLOTS + 1 and SLOT_W >= SAMPLE_W.
module aclink_bit_select
    import aclink_tx_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int SLOT_W    = DEF_SLOT_W,
    parameter int TAG_W     = DEF_TAG_W,
    parameter int BIT_W     = 5,
    parameter int SIDX_W    = 4
) (
    input  logic [NUM_SLOTS-1:0]          valid_sh,
    input  logic [NUM_SLOTS*SAMPLE_W-1:0] data_sh,
    input  phase_e                        phase,
    input  logic [SIDX_W-1:0]             slot,
    input  logic [BIT_W-1:0]              bit_idx,
    output logic                          bit_out
);
    localparam int EXT_W = 1 << BIT_W;
    localparam int PAD_W = SLOT_W - SAMPLE_W;

    logic [EXT_W-1:0] tag_word;
    logic [EXT_W-1:0] slot_word [NUM_SLOTS];

    // Tag word: frame-valid on top, slot flags below it, zeros elsewhere.
    always_comb begin
        tag_word            = '0;
        tag_word[TAG_W-1]   = |valid_sh;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            tag_word[TAG_W-2-s] = valid_sh[s];
        end
    end

    // One padded word per slot, zero when the slot is not valid.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            slot_word[g] = '0;
            if (valid_sh[g]) begin
                slot_word[g][SLOT_W-1:PAD_W] = data_sh[g*SAMPLE_W +: SAMPLE_W];
            end
        end
    end

    // Final bit multiplexer.
    always_comb begin
        if (phase == PH_TAG) begin
            bit_out = tag_word[bit_idx];
        end else if (int'(slot) < NUM_SLOTS) begin
            bit_out = slot_word[slot][bit_idx];
        end else begin
            bit_out = 1'b0;
        end
    end
endmodule

// File: rtl/aclink_frame_tx.sv
// Module: top of the outbound frame builder.
// Registers sync from the current position and serial data from the
// launch position, so data trails sync by one bit clock.
// Assumes: bit_clk is the codec bit clock; rst_n is synchronous.
module aclink_frame_tx
    import aclink_tx_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int SLOT_W    = DEF_SLOT_W,
    parameter int TAG_W     = DEF_TAG_W
) (
    input  logic                          bit_clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS-1:0]          slot_valid_i,
    input  logic [NUM_SLOTS*SAMPLE_W-1:0] slot_data_i,
    output logic                          sync_o,
    output logic                          sdout_o
);
    localparam int MAX_W  = (TAG_W > SLOT_W) ? TAG_W : SLOT_W;
    localparam int BIT_W  = $clog2(MAX_W);
    localparam int SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    phase_e                        cur_phase, lch_phase;
    logic                          frame_start, lch_en, sel_bit;
    logic [SIDX_W-1:0]             lch_slot;
    logic [BIT_W-1:0]              lch_bit;
    logic [NUM_SLOTS-1:0]          valid_sh;
    logic [NUM_SLOTS*SAMPLE_W-1:0] data_sh;

    aclink_bit_timer #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W),
        .BIT_W(BIT_W), .SIDX_W(SIDX_W)
    ) timer_i (
        .bit_clk(bit_clk), .rst_n(rst_n),
        .cur_phase(cur_phase), .frame_start(frame_start),
        .lch_phase(lch_phase), .lch_slot(lch_slot),
        .lch_bit(lch_bit), .lch_en(lch_en)
    );

    aclink_slot_shadow #(
        .NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W)
    ) shadow_i (
        .bit_clk(bit_clk), .rst_n(rst_n), .capture(frame_start),
        .valid_in(slot_valid_i), .data_in(slot_data_i),
        .valid_sh(valid_sh), .data_sh(data_sh)
    );

    aclink_bit_select #(
        .NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W),
        .TAG_W(TAG_W), .BIT_W(BIT_W), .SIDX_W(SIDX_W)
    ) select_i (
        .valid_sh(valid_sh), .data_sh(data_sh),
        .phase(lch_phase), .slot(lch_slot), .bit_idx(lch_bit),
        .bit_out(sel_bit)
    );

    // Output registers: sync follows the tag phase, data follows launch.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            sync_o  <= 1'b0;
            sdout_o <= 1'b0;
        end else begin
            sync_o  <= (cur_phase == PH_TAG);
            sdout_o <= lch_en & sel_bit;
        end
    end
endmodule

// File: rtl/aclink_frame_tx_chk.sv
// Checker: watches only the two output lines and rebuilds the frame
// position from the sync rising edge.
// Assumes: reset, once released, stays high for whole frames.
module aclink_frame_tx_chk #(
    parameter int NUM_SLOTS = 12,
    parameter int SAMPLE_W  = 16,
    parameter int SLOT_W    = 20,
    parameter int TAG_W     = 16
) (
    input logic bit_clk,
    input logic rst_n,
    input logic sync_o,
    input logic sdout_o
);
    localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic             sync_d, rst_d, pos_ok;
    logic [CNT_W-1:0] pos_q, run_q;
    logic             pad_pos;

    // Position of the bit on the line, restarted at each sync rise.
    always_ff @(posedge bit_clk) begin
        rst_d <= rst_n;
        if (!rst_n) begin
            sync_d <= 1'b0;
            pos_ok <= 1'b0;
            pos_q  <= '0;
            run_q  <= '0;
        end else begin
            sync_d <= sync_o;
            run_q  <= sync_o ? run_q + 1'b1 : '0;
            if (sync_o && !sync_d) begin
                pos_q  <= '0;
                pos_ok <= 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // Padding positions in the tag tail and in each slot tail.
    always_comb begin
        int p;
        p = int'(pos_q);
        if (p < TAG_W) pad_pos = (p > NUM_SLOTS);
        else           pad_pos = (((p - TAG_W) % SLOT_W) >= SAMPLE_W);
    end

    // Both outputs are quiet after any edge with reset low.
    always @(posedge bit_clk) begin
        if (rst_d === 1'b0) begin
            AST_RESET_QUIET: assert (!sync_o && !sdout_o); // R1
        end
    end

    AST_SYNC_RUN_MAX: assert property (@(posedge bit_clk) disable iff (!rst_n)
        sync_o |-> (int'(run_q) < TAG_W)); // R2

    AST_SYNC_RUN_FULL: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!sync_o && sync_d) |-> (int'(run_q) == TAG_W)); // R2

    AST_FRAME_LEN: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (sync_o && !sync_d && pos_ok) |-> (int'(pos_q) == FRAME_LEN - 1)); // R3

    AST_PAD_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pos_ok && pad_pos) |-> !sdout_o); // R7
endmodule

bind aclink_frame_tx aclink_frame_tx_chk #(
    .NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W)
) chk_i (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync_o(sync_o), .sdout_o(sdout_o)
);

// File: tb/aclink_frame_tx_tb_top.sv
// Bench: sweeps whole frames with many slot patterns and compares every
// bit of both lines against an arithmetic frame model.
module aclink_frame_tx_tb_top;
    localparam int NS   = 12;
    localparam int SW   = 16;
    localparam int FLEN = 256;

    logic             bit_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic [NS-1:0]    v_drv   = '0;
    logic [NS*SW-1:0] d_drv   = '0;
    logic             sync_o, sdout_o;

    logic [NS-1:0]    v_mod = '0;
    logic [NS*SW-1:0] d_mod = '0;
    int               n_chk = 0;
    int               n_bad = 0;
    bit               done  = 1'b0;
    logic [15:0]      lfsr  = 16'hACE1;

    aclink_frame_tx dut_i (
        .bit_clk(bit_clk), .rst_n(rst_n),
        .slot_valid_i(v_drv), .slot_data_i(d_drv),
        .sync_o(sync_o), .sdout_o(sdout_o)
    );

    always #2.5 bit_clk = ~bit_clk;

    function automatic logic [15:0] step(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    // Expected frame bit at position p, and the requirement it belongs to.
    function automatic logic exp_bit(input int p, output string req);
        int s, b, idx;
        if (p == 0) begin req = "R4"; return |v_mod; end
        if (p < 16) begin
            req = "R5";
            return (p <= NS) ? v_mod[p-1] : 1'b0;
        end
        s   = (p - 16) / 20;
        b   = (p - 16) % 20;
        idx = 19 - b;
        if (!v_mod[s]) begin req = "R8"; return 1'b0; end
        if (idx < 4)   begin req = "R7"; return 1'b0; end
        req = "R6 R9";
        return d_mod[s*SW + idx - 4];
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input int k);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s edge %0d: actual %b expected %b", req, k, act, exp);
        end
    endtask

    task automatic load_pattern(input int f);
        logic [NS-1:0] v;
        for (int s = 0; s < NS; s++) begin
            lfsr = step(lfsr);
            d_drv[s*SW +: SW] = lfsr;
        end
        if (f == 0)       v = '1;
        else if (f == 1)  v = '0;
        else if (f < 14)  begin v = '0; v[f-2] = 1'b1; d_drv = '1; end
        else if (f == 14) v = 12'hAAA;
        else if (f == 15) begin v = 12'h555; d_drv = {NS{16'h8001}}; end
        else              v = lfsr[NS-1:0];
        v_drv = v;
    endtask

    // Runs nfr frames from a fresh release of reset, checking every edge.
    task automatic run_frames(input int nfr, input int f0);
        string req;
        logic  e;
        int    pos;
        for (int k = 1; k <= nfr * FLEN; k++) begin
            @(posedge bit_clk);
            #1;
            pos = (k - 1) % FLEN;
            chk(sync_o, (pos < 16), "R2", k);
            if (k == 1) begin
                chk(sdout_o, 1'b0, "R1", k);
            end else begin
                e = exp_bit((k - 2) % FLEN, req);
                if (k == 2) req = "R3";
                chk(sdout_o, e, req, k);
            end
            if (pos == 0) begin
                v_mod = v_drv;  // R9: capture happens on the sync-raising edge
                d_mod = d_drv;
            end
            @(negedge bit_clk);
            if (pos == 100) begin
                v_drv = ~v_drv;
                d_drv = ~d_drv;
            end
            if (pos == 200) load_pattern(f0 + (k - 1) / FLEN + 1);
        end
    endtask

    initial begin
        load_pattern(0);
        for (int i = 0; i < 4; i++) begin
            @(posedge bit_clk);
            #1;
            chk(sync_o, 1'b0, "R1", -i);
            chk(sdout_o, 1'b0, "R1", -i);
        end
        @(negedge bit_clk);
        rst_n = 1'b1;
        run_frames(17, 0);
        // Mid-frame reset burst, then a clean restart.
        for (int k = 0; k < 37; k++) @(posedge bit_clk);
        @(negedge bit_clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge bit_clk);
            #1;
            chk(sync_o, 1'b0, "R1", -i);
            chk(sdout_o, 1'b0, "R1", -i);
        end
        @(negedge bit_clk);
        load_pattern(0);
        rst_n = 1'b1;
        run_frames(2, 20);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule